// File: doc/BRIEF.md
# Double-Action Compare PWM Channel

This timer channel watches a shared 16-bit counter bus and drives a single output pin. It keeps two compare registers. In output PWM mode a hit on register A raises the pin and a hit on the active copy of register B drops it. Register B is double-buffered. Software writes always land in a staging copy. The active copy is refreshed from the staging copy only at points where swapping it cannot produce a truncated or stretched pulse.

The compare width is a parameter between 8 and 16 bits. When it is narrower than 16, bit 15 of B turns into a full-duty flag that holds the pin high with no glitch, however the flag is reached. In the two capture modes the pin is an input. A chosen edge latches the counter into A and pushes the old A into B, so software can read two successive timestamps.

After reset the channel sits idle with the pin driver off. Software writes A and B, then selects a mode. Leaving PWM for idle and re-entering it recovers a channel whose B value can never match the counter.

Top module: `dac_pwm_chan`

## Requirements
- R1: While reset is held and after it is released, the pin driver enable `pin_oe_o` and the pin value `pin_o` are 0.
- R2: In PWM mode (mode code 3), a compare hit on A sets `pin_o` to 1 on the next clock edge, a hit on active B clears it, and with no hit the pin holds its value.
- R3: Compares use only the low RES bits of the counter, of A and of active B (default RES = 12), so counter bits at and above RES are ignored.
- R4: A write with `wr_sel_i` = 1 updates the staging B. In PWM mode the staging value is copied to active B (seen on `b_o`) only on an edge where the pin is low, or where staging or active B carries the full-duty flag. While the pin is high and neither copy carries the flag, `b_o` does not change.
- R5: When A and active B hit in the same cycle in PWM mode, the pin is low after that edge.
- R6: With RES < 16, bit 15 of active B forces the pin high and blocks any clear by B. A write setting the flag while the pin is low raises the pin on the second edge after the write edge.
- R7: If the flag is written while the pin is high, the pin stays high through every following cycle of PWM mode, including cycles where the counter equals the old active B.
- R8: On the edge where the mode becomes PWM from any other mode, the pin goes low, `pin_oe_o` goes to 1, and active B takes the staging value. A channel stuck with an unreachable B recovers through idle and a new B.
- R9: In idle (mode code 0) the pin is released: `pin_oe_o` and `pin_o` are 0 after the next edge, and B writes reach only the staging copy.
- R10: In capture modes (code 1 = rising edge of `pin_i`, code 2 = falling edge), an edge loads the full 16-bit counter into A, and the previous A into both B copies, on the same clock edge.
- R11: A capture has priority over a software write in the same cycle, to either A or B.
- R12: In capture modes `pin_oe_o` is 0 and a B write without a capture updates active B at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 idle, 1 capture rising, 2 capture falling, 3 PWM |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects A, 1 selects B |
| wr_data_i | input | 16 | Write data |
| cnt_i | input | 16 | Counter bus value |
| pin_i | input | 1 | Pin level for capture |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin driver enable |
| a_o | output | 16 | Register A content |
| b_o | output | 16 | Active B content |

## Verification
Two pairs of functions can land on the same clock edge. In PWM mode, an A hit and a B hit can coincide. In a capture mode, a capture transfer and a software write to B can coincide. The bench sets A equal to B and presents that count, and it expects the pin low afterwards. It also issues B and A writes on the very cycle a pin edge arrives, and it expects `a_o` and `b_o` to show the capture result rather than the written data. A third coincidence is a B clear arriving in the cycle after the full-duty flag is written with the pin high. The bench judges it by requiring the pin to stay high in every cycle.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
  localparam int unsigned BUS_W = 16;

  typedef enum logic [1:0] {
    CH_IDLE     = 2'b00,
    CH_CAP_RISE = 2'b01,
    CH_CAP_FALL = 2'b10,
    CH_OPWM     = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/dcpwm_match.sv
module dcpwm_match
  import dcpwm_pkg::*;
#(
  parameter int unsigned RES = 12
) (
  input  logic [BUS_W-1:0] cnt,
  input  logic [BUS_W-1:0] a_val,
  input  logic [BUS_W-1:0] b_val,
  output logic             hit_a,
  output logic             hit_b
);
  localparam logic [BUS_W-1:0] CMP_MASK = BUS_W'((32'd1 << RES) - 32'd1);

  logic [BUS_W-1:0] cnt_m;

  always_comb begin
    cnt_m = cnt & CMP_MASK;
    hit_a = (cnt_m == (a_val & CMP_MASK));
    hit_b = (cnt_m == (b_val & CMP_MASK));
  end
endmodule

// File: rtl/dcpwm_regs.sv
module dcpwm_regs
  import dcpwm_pkg::*;
#(
  parameter int unsigned RES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_enter,
  input  logic             pwm_stay,
  input  logic             cap_mode,
  input  logic             cap_evt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [BUS_W-1:0] cnt,
  input  logic             pin_q,
  output logic [BUS_W-1:0] a_q,
  output logic [BUS_W-1:0] b1_q,
  output logic [BUS_W-1:0] b2_q,
  output logic             b1_full,
  output logic             b2_full
);
  localparam bit HAS_FULL = (RES < BUS_W);

  logic [BUS_W-1:0] a_d, b1_d, b2_d;
  logic             a_en, b1_en, b2_en;
  logic             swap_ok;

  generate
    if (HAS_FULL) begin : g_full
      assign b1_full = b1_q[BUS_W-1];
      assign b2_full = b2_q[BUS_W-1];
    end else begin : g_nofull
      assign b1_full = 1'b0;
      assign b2_full = 1'b0;
    end
  endgenerate

  // Active B may be refreshed while the pin is low, or when either copy
  // carries the full-duty flag (entering or leaving full duty).
  assign swap_ok = !pin_q || b1_full || b2_full;

  always_comb begin
    a_en  = 1'b0;
    a_d   = a_q;
    b1_en = 1'b0;
    b1_d  = b1_q;
    b2_en = 1'b0;
    b2_d  = b2_q;
    if (cap_evt) begin
      a_en  = 1'b1;
      a_d   = cnt;
      b1_en = 1'b1;
      b1_d  = a_q;
      b2_en = 1'b1;
      b2_d  = a_q;
    end else begin
      if (wr_en && !wr_sel) begin
        a_en = 1'b1;
        a_d  = wr_data;
      end
      if (wr_en && wr_sel) begin
        b1_en = 1'b1;
        b1_d  = wr_data;
      end
      if (cap_mode && wr_en && wr_sel) begin
        b2_en = 1'b1;
        b2_d  = wr_data;
      end else if (pwm_enter || (pwm_stay && swap_ok)) begin
        b2_en = 1'b1;
        b2_d  = b1_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (a_en)  a_q  <= a_d;
    if (b1_en) b1_q <= b1_d;
    if (b2_en) b2_q <= b2_d;
  end

  // R4
  b_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_stay && pin_q && !b1_full && !b2_full) |=> $stable(b2_q));

  // R10
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ((a_q == $past(cnt)) && (b2_q == $past(a_q)) && (b1_q == $past(a_q))));
endmodule

// File: rtl/dcpwm_pin.sv
module dcpwm_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_enter,
  input  logic pwm_stay,
  input  logic hit_a,
  input  logic hit_b,
  input  logic b1_full,
  input  logic b2_full,
  output logic pin_q
);
  logic pin_d;

  always_comb begin
    if (!pwm_stay) begin
      pin_d = 1'b0;
    end else if (b2_full) begin
      pin_d = 1'b1;
    end else if (hit_b && !b1_full) begin
      pin_d = 1'b0;
    end else if (hit_a) begin
      pin_d = 1'b1;
    end else begin
      pin_d = pin_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  // R5
  tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_stay && hit_a && hit_b && !b1_full && !b2_full) |=> !pin_q);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_stay && pin_q && (b1_full || b2_full)) |=> pin_q);

  // R8
  enter_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_enter |=> !pin_q);
endmodule

// File: rtl/dac_pwm_chan.sv
module dac_pwm_chan
  import dcpwm_pkg::*;
#(
  parameter int unsigned RES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [15:0] wr_data_i,
  input  logic [15:0] cnt_i,
  input  logic        pin_i,
  output logic        pin_o,
  output logic        pin_oe_o,
  output logic [15:0] a_o,
  output logic [15:0] b_o
);
  logic [1:0] rst_pipe;
  logic       rst_s;
  ch_mode_e   mode_n, mode_q;
  logic       pin_prev_q;
  logic       pwm_enter, pwm_stay, cap_mode, cap_evt;
  logic       hit_a, hit_b, b1_full, b2_full, pin_q;
  logic [BUS_W-1:0] a_q, b1_q, b2_q;

  initial begin
    if (RES < 8 || RES > BUS_W) $error("RES must lie in 8..16");
  end

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  always_comb begin
    mode_n    = ch_mode_e'(mode_i);
    pwm_enter = (mode_n == CH_OPWM) && (mode_q != CH_OPWM);
    pwm_stay  = (mode_n == CH_OPWM) && (mode_q == CH_OPWM);
    cap_mode  = (mode_n == CH_CAP_RISE) || (mode_n == CH_CAP_FALL);
    cap_evt   = ((mode_n == CH_CAP_RISE) && pin_i && !pin_prev_q) ||
                ((mode_n == CH_CAP_FALL) && !pin_i && pin_prev_q);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q     <= CH_IDLE;
      pin_prev_q <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      pin_prev_q <= pin_i;
    end
  end

  dcpwm_match #(.RES(RES)) u_match (
    .cnt   (cnt_i),
    .a_val (a_q),
    .b_val (b2_q),
    .hit_a (hit_a),
    .hit_b (hit_b)
  );

  dcpwm_regs #(.RES(RES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .pwm_enter (pwm_enter),
    .pwm_stay  (pwm_stay),
    .cap_mode  (cap_mode),
    .cap_evt   (cap_evt),
    .wr_en     (wr_en_i),
    .wr_sel    (wr_sel_i),
    .wr_data   (wr_data_i),
    .cnt       (cnt_i),
    .pin_q     (pin_q),
    .a_q       (a_q),
    .b1_q      (b1_q),
    .b2_q      (b2_q),
    .b1_full   (b1_full),
    .b2_full   (b2_full)
  );

  dcpwm_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_s),
    .pwm_enter (pwm_enter),
    .pwm_stay  (pwm_stay),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .b1_full   (b1_full),
    .b2_full   (b2_full),
    .pin_q     (pin_q)
  );

  assign pin_o    = pin_q;
  assign pin_oe_o = (mode_q == CH_OPWM);
  assign a_o      = a_q;
  assign b_o      = b2_q;

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_n == CH_IDLE) |=> (!pin_oe_o && !pin_o));

  // R12
  cap_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cap_mode |=> !pin_oe_o);
endmodule

// File: tb/dac_pwm_chan_tb_top.sv
module dac_pwm_chan_tb_top;
  localparam logic [1:0] IDL = 2'd0, CRI = 2'd1, CFA = 2'd2, PWM = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        wr_en, wr_sel, pin_in;
  logic [15:0] wr_data, cnt;
  logic        pin_o, pin_oe_o;
  logic [15:0] a_o, b_o;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  typedef struct {
    string       tag;
    bit          cp;
    logic        pin;
    bit          co;
    logic        oe;
    bit          ca;
    logic [15:0] a;
    bit          cb;
    logic [15:0] b;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  dac_pwm_chan dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .cnt_i(cnt), .pin_i(pin_in),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .a_o(a_o), .b_o(b_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Driver: applies one cycle of stimulus on the falling edge.
  task automatic drv(input logic [1:0] m, input logic we, input logic ws,
                     input logic [15:0] wd, input logic [15:0] c, input logic pi);
    @(negedge clk);
    mode = m; wr_en = we; wr_sel = ws; wr_data = wd; cnt = c; pin_in = pi;
  endtask

  // Expectation for the outputs after the coming rising edge.
  task automatic expect_o(input string tag, input bit cp, input logic p,
                          input bit co, input logic oe, input bit ca,
                          input logic [15:0] a, input bit cb, input logic [15:0] b);
    exp_t e;
    e.tag = tag; e.cp = cp; e.pin = p; e.co = co; e.oe = oe;
    e.ca = ca; e.a = a; e.cb = cb; e.b = b;
    sb_q.push_back(e);
  endtask

  task automatic pw(input string tag, input logic [15:0] c, input logic p);
    drv(PWM, 1'b0, 1'b0, 16'h0, c, 1'b0);
    expect_o(tag, 1, p, 0, 1'b0, 0, 16'h0, 0, 16'h0);
  endtask

  task automatic pwb(input string tag, input logic [15:0] c, input logic p,
                     input logic [15:0] b);
    drv(PWM, 1'b0, 1'b0, 16'h0, c, 1'b0);
    expect_o(tag, 1, p, 0, 1'b0, 0, 16'h0, 1, b);
  endtask

  // Monitor: pops one expectation per rising edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.cp) check(e.tag, "pin_o", {15'd0, pin_o}, {15'd0, e.pin});
        if (e.co) check(e.tag, "pin_oe_o", {15'd0, pin_oe_o}, {15'd0, e.oe});
        if (e.ca) check(e.tag, "a_o", a_o, e.a);
        if (e.cb) check(e.tag, "b_o", b_o, e.b);
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    mode = IDL; wr_en = 0; wr_sel = 0; wr_data = 0; cnt = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    check("R1", "pin_oe_o in reset", {15'd0, pin_oe_o}, 16'd0);
    check("R1", "pin_o in reset", {15'd0, pin_o}, 16'd0);
    rst_n = 1'b1;
    drv(IDL, 0, 0, 16'h0, 16'h0, 0);
    drv(IDL, 0, 0, 16'h0, 16'h0, 0);
    expect_o("R1", 1, 1'b0, 1, 1'b0, 0, 16'h0, 0, 16'h0);

    // Load A and staging B in idle
    drv(IDL, 1, 0, 16'h0010, 16'h0, 0);
    expect_o("R9", 1, 1'b0, 1, 1'b0, 1, 16'h0010, 0, 16'h0);
    drv(IDL, 1, 1, 16'h0020, 16'h0, 0);

    // R8 entry: pin low, driver on, B copied
    drv(PWM, 0, 0, 16'h0, 16'h0, 0);
    expect_o("R8", 1, 1'b0, 1, 1'b1, 0, 16'h0, 1, 16'h0020);
    pw("R2", 16'h0010, 1'b1);
    pw("R2", 16'h0011, 1'b1);
    pw("R2", 16'h0020, 1'b0);
    pw("R3", 16'hF010, 1'b1);
    pw("R3", 16'h1020, 1'b0);

    // R4 double buffering
    pw("R2", 16'h0010, 1'b1);
    drv(PWM, 1, 1, 16'h0030, 16'h0011, 0);
    expect_o("R4", 1, 1'b1, 0, 1'b0, 0, 16'h0, 1, 16'h0020);
    pwb("R4", 16'h0012, 1'b1, 16'h0020);
    pwb("R4", 16'h0020, 1'b0, 16'h0020);
    pwb("R4", 16'h0021, 1'b0, 16'h0030);

    // R5 equal A and B
    pw("R2", 16'h0010, 1'b1);
    drv(PWM, 1, 0, 16'h0030, 16'h0011, 0);
    expect_o("R5", 1, 1'b1, 0, 1'b0, 1, 16'h0030, 0, 16'h0);
    pw("R5", 16'h0030, 1'b0);
    pw("R5", 16'h0030, 1'b0);

    // R6 full duty requested while low
    drv(PWM, 1, 1, 16'h8030, 16'h0000, 0);
    expect_o("R6", 1, 1'b0, 0, 1'b0, 0, 16'h0, 1, 16'h0030);
    pwb("R6", 16'h0000, 1'b0, 16'h8030);
    pw("R6", 16'h0000, 1'b1);
    pw("R6", 16'h0030, 1'b1);

    // Leave full duty while high
    drv(PWM, 1, 1, 16'h0040, 16'h0031, 0);
    expect_o("R6", 1, 1'b1, 0, 1'b0, 0, 16'h0, 1, 16'h8030);
    pwb("R4", 16'h0032, 1'b1, 16'h0040);
    pw("R2", 16'h0040, 1'b0);
    pw("R2", 16'h0041, 1'b0);

    // R7 full duty requested while high
    pw("R2", 16'h0030, 1'b1);
    drv(PWM, 1, 1, 16'h8040, 16'h0031, 0);
    expect_o("R7", 1, 1'b1, 0, 1'b0, 0, 16'h0, 0, 16'h0);
    pw("R7", 16'h0040, 1'b1);
    pwb("R7", 16'h0040, 1'b1, 16'h8040);
    pw("R7", 16'h0041, 1'b1);

    // R8 unreachable B, recovery through idle
    drv(PWM, 1, 1, 16'h0050, 16'h0100, 0);
    expect_o("R7", 1, 1'b1, 0, 1'b0, 0, 16'h0, 0, 16'h0);
    pwb("R8", 16'h0200, 1'b1, 16'h0050);
    pw("R8", 16'h0300, 1'b1);
    pw("R8", 16'h0100, 1'b1);
    drv(IDL, 0, 0, 16'h0, 16'h0200, 0);
    expect_o("R9", 1, 1'b0, 1, 1'b0, 0, 16'h0, 0, 16'h0);
    drv(IDL, 1, 1, 16'h0200, 16'h0200, 0);
    expect_o("R9", 1, 1'b0, 1, 1'b0, 0, 16'h0, 1, 16'h0050);
    drv(PWM, 0, 0, 16'h0, 16'h0101, 0);
    expect_o("R8", 1, 1'b0, 1, 1'b1, 0, 16'h0, 1, 16'h0200);
    drv(PWM, 1, 0, 16'h0150, 16'h0101, 0);
    expect_o("R8", 1, 1'b0, 0, 1'b0, 1, 16'h0150, 0, 16'h0);
    pw("R8", 16'h0150, 1'b1);
    pw("R8", 16'h0200, 1'b0);

    // Capture modes
    drv(IDL, 0, 0, 16'h0, 16'h0, 0);
    expect_o("R9", 1, 1'b0, 1, 1'b0, 0, 16'h0, 0, 16'h0);
    drv(CRI, 0, 0, 16'h0, 16'h1234, 0);
    expect_o("R12", 0, 1'b0, 1, 1'b0, 1, 16'h0150, 0, 16'h0);
    drv(CRI, 0, 0, 16'h0, 16'h1235, 1);
    expect_o("R10", 0, 1'b0, 1, 1'b0, 1, 16'h1235, 1, 16'h0150);
    drv(CRI, 0, 0, 16'h0, 16'h1236, 1);
    expect_o("R10", 0, 1'b0, 0, 1'b0, 1, 16'h1235, 1, 16'h0150);
    drv(CRI, 1, 1, 16'hBEEF, 16'h2000, 1);
    expect_o("R12", 0, 1'b0, 1, 1'b0, 1, 16'h1235, 1, 16'hBEEF);
    drv(CFA, 0, 0, 16'h0, 16'h3000, 1);
    expect_o("R10", 0, 1'b0, 0, 1'b0, 1, 16'h1235, 0, 16'h0);
    drv(CFA, 1, 1, 16'h7777, 16'h4444, 0);
    expect_o("R11", 0, 1'b0, 0, 1'b0, 1, 16'h4444, 1, 16'h1235);
    drv(CRI, 1, 0, 16'h5555, 16'h6666, 1);
    expect_o("R11", 0, 1'b0, 0, 1'b0, 1, 16'h6666, 1, 16'h4444);
    drv(IDL, 0, 0, 16'h0, 16'h0, 0);
    expect_o("R9", 1, 1'b0, 1, 1'b0, 0, 16'h0, 0, 16'h0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule